// File: doc/BRIEF.md
# Hierarchical Route Port Selector

This block picks the output port for one packet at one switch of a two-tier, fully connected network. Switches form groups. Global links join the groups to each other, and local links join the switches inside a group. Each request carries the routing fields of a packet header. The block answers one cycle later with the chosen output port and the header fields that the packet must carry to the next hop.

Two writable tables hold the routes. One is indexed by destination switch and is used for traffic inside the own group. The other is indexed by target group and is used for traffic that leaves the group. Each table entry holds a primary way and an alternate way, and each way has its own valid bit.

The route mode is fixed when the packet is injected. Four modes exist: a single direct path, alternating direct paths, and indirect routing through an intermediate group. The intermediate group is chosen either in round-robin order or from a pseudo-random sequence. The block also checks each packet against a hop budget.

Top module: `hier_route_sel`

## Requirements
- R1: After reset, rsp_valid_o is low and every way of both tables is invalid.
- R2: A request sampled on a clock edge gives exactly one response, with rsp_valid_o high after that same edge. A cycle with no request gives rsp_valid_o low.
- R3: If the destination group equals my_grp_i and the destination switch equals my_sw_i, the port is the destination host index (host ports are 0 to 7). The hop count is passed through unchanged.
- R4: If the target group is the own group and the destination switch differs from my_sw_i, the port comes from the intra-group table entry of the destination switch, and the hop count rises by 1.
- R5: If the target group differs from my_grp_i, the port comes from the inter-group table entry of the target group, and the hop count rises by 1. Mode values: 0 single direct, 1 alternating direct, 2 indirect round-robin, 3 indirect random.
- R6: In mode 1 at injection (hop count 0), the alternate flag sent out takes the value of an internal toggle. The toggle is 0 after reset and flips on every mode-1 injection. On later hops the flag from the header is used. With the flag at 1, way b is used if it is valid; otherwise way a is used.
- R7: In mode 2 at injection, when the destination is in another group, the indirect flag is set and the intermediate group becomes the k-th candidate. Candidates are the groups in ascending order, leaving out the own group and the destination group. k counts 0 to NUM_GROUPS-3, wraps to 0, and advances once per such injection.
- R8: In mode 3 at injection toward another group, k is the current 16-bit LFSR value modulo NUM_GROUPS-2. The LFSR starts at 0xACE1. It advances once per such injection, shifting left and taking in the XOR of bits 15, 13, 12 and 10.
- R9: An indirect-mode injection whose destination is in the own group is routed directly. It leaves the indirect flag at 0 and advances neither the round-robin count nor the LFSR.
- R10: While the indirect flag is set and the intermediate group differs from my_grp_i, the packet is routed toward the intermediate group. At the intermediate group the flag is cleared, and the packet is routed toward its destination group.
- R11: A non-delivery lookup that finds the selected way invalid raises err_tbl_o and sends the packet to the service port (55).
- R12: A non-delivery request whose hop count in is at least 3 (modes 0 and 1) or at least 5 (modes 2 and 3) raises err_hop_o and sends the packet to the service port. A delivery is never a hop error.
- R13: A write with wr_inter_i low loads intra-group entry wr_idx_i, and a write with wr_inter_i high loads inter-group entry wr_idx_i. The new entry is used from the next request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| my_grp_i | input | GRP_W | Group of this switch |
| my_sw_i | input | SW_W | Index of this switch within its group |
| wr_en_i | input | 1 | Table write strobe |
| wr_inter_i | input | 1 | 1 selects the inter-group table, 0 the intra-group table |
| wr_idx_i | input | IDX_W | Entry written |
| wr_va_i | input | 1 | Valid bit of way a |
| wr_pa_i | input | PORT_W | Port of way a |
| wr_vb_i | input | 1 | Valid bit of way b |
| wr_pb_i | input | PORT_W | Port of way b |
| req_valid_i | input | 1 | Request strobe |
| hdr_mode_i | input | 2 | Route mode |
| hdr_ind_i | input | 1 | Indirect flag in |
| hdr_alt_i | input | 1 | Alternate flag in |
| hdr_mid_grp_i | input | GRP_W | Intermediate group in |
| hdr_dst_grp_i | input | GRP_W | Destination group |
| hdr_dst_sw_i | input | SW_W | Destination switch |
| hdr_dst_host_i | input | HOST_W | Destination host port |
| hdr_hops_i | input | HOP_W | Hops taken so far |
| rsp_valid_o | output | 1 | Response strobe |
| port_o | output | PORT_W | Chosen output port |
| err_tbl_o | output | 1 | Invalid table way hit |
| err_hop_o | output | 1 | Hop budget exceeded |
| hdr_ind_o | output | 1 | Indirect flag out |
| hdr_alt_o | output | 1 | Alternate flag out |
| hdr_mid_grp_o | output | GRP_W | Intermediate group out |
| hdr_hops_o | output | HOP_W | Hop count out |

## Verification
All internal state is visible on the response that follows the first request that uses it. A round-robin count that is off by one, or that advances on the wrong request, shows as a wrong hdr_mid_grp_o on the next mode-2 injection. A wrong LFSR step shows on the next mode-3 injection. A toggle that flips at the wrong time shows in hdr_alt_o and port_o on the next mode-1 injection. A wrong table write shows as a wrong port or a spurious err_tbl_o one cycle after the first lookup of that entry. A wrong hop limit shows on the boundary requests with 3 and 5 hops.

// File: rtl/route_pkg.sv
package route_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_MULTI    = 2'd1,
    MODE_IND_RR   = 2'd2,
    MODE_IND_RAND = 2'd3
  } route_mode_e;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/rps_route_table.sv
module rps_route_table #(
  parameter int DEPTH  = 8,
  parameter int PORT_W = 6,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic              wva_i,
  input  logic [PORT_W-1:0] wpa_i,
  input  logic              wvb_i,
  input  logic [PORT_W-1:0] wpb_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic              rva_o,
  output logic [PORT_W-1:0] rpa_o,
  output logic              rvb_o,
  output logic [PORT_W-1:0] rpb_o
);
  logic [DEPTH-1:0]       va_q, vb_q;
  logic [PORT_W-1:0]      pa_q [DEPTH];
  logic [PORT_W-1:0]      pb_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        va_q[e] <= 1'b0;
        vb_q[e] <= 1'b0;
        pa_q[e] <= '0;
        pb_q[e] <= '0;
      end else if (we_i && widx_i == IDX_W'(e)) begin
        va_q[e] <= wva_i;
        vb_q[e] <= wvb_i;
        pa_q[e] <= wpa_i;
        pb_q[e] <= wpb_i;
      end
    end
  end

  assign rva_o = va_q[ridx_i];
  assign rvb_o = vb_q[ridx_i];
  assign rpa_o = pa_q[ridx_i];
  assign rpb_o = pb_q[ridx_i];
endmodule

// File: rtl/rps_mid_pick.sv
module rps_mid_pick #(
  parameter int NUM_GROUPS = 8,
  localparam int GRP_W = $clog2(NUM_GROUPS),
  localparam int CAND  = NUM_GROUPS - 2,
  localparam int CNT_W = (CAND > 1) ? $clog2(CAND) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GRP_W-1:0] src_i,
  input  logic [GRP_W-1:0] dst_i,
  input  logic             adv_rr_i,
  input  logic             adv_rand_i,
  output logic [GRP_W-1:0] mid_rr_o,
  output logic [GRP_W-1:0] mid_rand_o
);
  import route_pkg::*;

  logic [CNT_W-1:0] rr_q;
  logic [15:0]      lfsr_q;
  logic [CNT_W-1:0] rand_k;

  // k-th group in ascending order, skipping src and dst
  function automatic logic [GRP_W-1:0] skip_map(input logic [CNT_W-1:0] k,
                                                input logic [GRP_W-1:0] a,
                                                input logic [GRP_W-1:0] b);
    logic [GRP_W-1:0] lo, hi, g;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    g  = GRP_W'(k);
    if (g >= lo) g = g + GRP_W'(1);
    if (g >= hi) g = g + GRP_W'(1);
    return g;
  endfunction

  assign rand_k     = CNT_W'(lfsr_q % 16'(CAND));
  assign mid_rr_o   = skip_map(rr_q, src_i, dst_i);
  assign mid_rand_o = skip_map(rand_k, src_i, dst_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q   <= '0;
      lfsr_q <= LFSR_SEED;
    end else begin
      if (adv_rr_i) rr_q <= (rr_q == CNT_W'(CAND - 1)) ? '0 : rr_q + CNT_W'(1);
      if (adv_rand_i) lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end
  end

  assert_rr_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rr_q <= CNT_W'(CAND - 1));
  assert_lfsr_alive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_rand_i |=> lfsr_q != 16'h0000);
endmodule

// File: rtl/hier_route_sel.sv
module hier_route_sel #(
  parameter int NUM_GROUPS   = 8,
  parameter int SW_PER_GROUP = 8,
  parameter int NUM_HOSTS    = 8,
  parameter int NUM_PORTS    = 56,
  parameter int HOP_W        = 3,
  parameter int MAX_DIRECT   = 3,
  parameter int MAX_INDIRECT = 5,
  localparam int GRP_W  = $clog2(NUM_GROUPS),
  localparam int SW_W   = $clog2(SW_PER_GROUP),
  localparam int HOST_W = $clog2(NUM_HOSTS),
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int IDX_W  = (GRP_W > SW_W) ? GRP_W : SW_W,
  localparam logic [PORT_W-1:0] SVC_PORT = PORT_W'(NUM_PORTS - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GRP_W-1:0]  my_grp_i,
  input  logic [SW_W-1:0]   my_sw_i,
  input  logic              wr_en_i,
  input  logic              wr_inter_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_va_i,
  input  logic [PORT_W-1:0] wr_pa_i,
  input  logic              wr_vb_i,
  input  logic [PORT_W-1:0] wr_pb_i,
  input  logic              req_valid_i,
  input  logic [1:0]        hdr_mode_i,
  input  logic              hdr_ind_i,
  input  logic              hdr_alt_i,
  input  logic [GRP_W-1:0]  hdr_mid_grp_i,
  input  logic [GRP_W-1:0]  hdr_dst_grp_i,
  input  logic [SW_W-1:0]   hdr_dst_sw_i,
  input  logic [HOST_W-1:0] hdr_dst_host_i,
  input  logic [HOP_W-1:0]  hdr_hops_i,
  output logic              rsp_valid_o,
  output logic [PORT_W-1:0] port_o,
  output logic              err_tbl_o,
  output logic              err_hop_o,
  output logic              hdr_ind_o,
  output logic              hdr_alt_o,
  output logic [GRP_W-1:0]  hdr_mid_grp_o,
  output logic [HOP_W-1:0]  hdr_hops_o
);
  import route_pkg::*;

  route_mode_e      mode;
  logic             inject, ind_mode, start_ind, ind_n, alt_n, alt_q;
  logic             to_remote, to_local, deliver, use_b, hit;
  logic             tbl_err, hop_err;
  logic [GRP_W-1:0] mid_rr, mid_rand, mid_n, tgt;
  logic [HOP_W-1:0] limit;
  logic [PORT_W-1:0] port_n;
  logic             adv_rr, adv_rand;

  logic              ia_v, ib_v, ea_v, eb_v;
  logic [PORT_W-1:0] ia_p, ib_p, ea_p, eb_p;

  assign mode      = route_mode_e'(hdr_mode_i);
  assign inject    = (hdr_hops_i == '0);
  assign ind_mode  = hdr_mode_i[1];
  assign start_ind = inject && ind_mode && (hdr_dst_grp_i != my_grp_i) && (NUM_GROUPS >= 3);
  assign adv_rr    = req_valid_i && start_ind && (mode == MODE_IND_RR);
  assign adv_rand  = req_valid_i && start_ind && (mode == MODE_IND_RAND);

  assign ind_n  = start_ind || (hdr_ind_i && (hdr_mid_grp_i != my_grp_i));
  assign mid_n  = start_ind ? ((mode == MODE_IND_RR) ? mid_rr : mid_rand) : hdr_mid_grp_i;
  assign alt_n  = (inject && mode == MODE_MULTI) ? alt_q : hdr_alt_i;
  assign tgt    = ind_n ? mid_n : hdr_dst_grp_i;

  assign to_remote = (tgt != my_grp_i);
  assign to_local  = !to_remote && (hdr_dst_sw_i != my_sw_i);
  assign deliver   = !to_remote && !to_local;

  rps_route_table #(.DEPTH(SW_PER_GROUP), .PORT_W(PORT_W)) u_intra (
    .clk_i, .rst_ni,
    .we_i  (wr_en_i && !wr_inter_i),
    .widx_i(SW_W'(wr_idx_i)),
    .wva_i (wr_va_i), .wpa_i(wr_pa_i), .wvb_i(wr_vb_i), .wpb_i(wr_pb_i),
    .ridx_i(hdr_dst_sw_i),
    .rva_o (ia_v), .rpa_o(ia_p), .rvb_o(ib_v), .rpb_o(ib_p)
  );

  rps_route_table #(.DEPTH(NUM_GROUPS), .PORT_W(PORT_W)) u_inter (
    .clk_i, .rst_ni,
    .we_i  (wr_en_i && wr_inter_i),
    .widx_i(GRP_W'(wr_idx_i)),
    .wva_i (wr_va_i), .wpa_i(wr_pa_i), .wvb_i(wr_vb_i), .wpb_i(wr_pb_i),
    .ridx_i(tgt),
    .rva_o (ea_v), .rpa_o(ea_p), .rvb_o(eb_v), .rpb_o(eb_p)
  );

  if (NUM_GROUPS >= 3) begin : g_pick
    rps_mid_pick #(.NUM_GROUPS(NUM_GROUPS)) u_pick (
      .clk_i, .rst_ni,
      .src_i     (my_grp_i),
      .dst_i     (hdr_dst_grp_i),
      .adv_rr_i  (adv_rr),
      .adv_rand_i(adv_rand),
      .mid_rr_o  (mid_rr),
      .mid_rand_o(mid_rand)
    );
  end else begin : g_nopick
    assign mid_rr   = '0;
    assign mid_rand = '0;
  end

  always_comb begin
    use_b = alt_n && (to_remote ? eb_v : ib_v);
    if (to_remote) begin
      hit    = use_b || ea_v;
      port_n = use_b ? eb_p : ea_p;
    end else begin
      hit    = use_b || ia_v;
      port_n = use_b ? ib_p : ia_p;
    end
    if (deliver) port_n = PORT_W'(hdr_dst_host_i);
  end

  assign limit   = ind_mode ? HOP_W'(MAX_INDIRECT) : HOP_W'(MAX_DIRECT);
  assign tbl_err = !deliver && !hit;
  assign hop_err = !deliver && (hdr_hops_i >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alt_q <= 1'b0;
    else if (req_valid_i && inject && mode == MODE_MULTI) alt_q <= !alt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      port_o        <= '0;
      err_tbl_o     <= 1'b0;
      err_hop_o     <= 1'b0;
      hdr_ind_o     <= 1'b0;
      hdr_alt_o     <= 1'b0;
      hdr_mid_grp_o <= '0;
      hdr_hops_o    <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        port_o        <= (tbl_err || hop_err) ? SVC_PORT : port_n;
        err_tbl_o     <= tbl_err;
        err_hop_o     <= hop_err;
        hdr_ind_o     <= ind_n;
        hdr_alt_o     <= alt_n;
        hdr_mid_grp_o <= mid_n;
        hdr_hops_o    <= deliver ? hdr_hops_i : hdr_hops_i + HOP_W'(1);
      end
    end
  end

  assert_rsp_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_no_rsp_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  assert_err_to_svc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && (err_tbl_o || err_hop_o)) |-> port_o == SVC_PORT);
  assert_ind_away_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && hdr_ind_o) |-> hdr_mid_grp_o != my_grp_i);
endmodule

// File: tb/hier_route_sel_tb.sv
module hier_route_sel_tb;
  localparam int G = 8;
  localparam logic [2:0] MY_G = 3'd2;
  localparam logic [2:0] MY_S = 3'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0] my_grp, my_sw, wr_idx, mid_i, dgrp, dsw, dhost, hops_i, mid_o, hops_o;
  logic wr_en, wr_inter, wr_va, wr_vb, req, ind_i, alt_i;
  logic [5:0] wr_pa, wr_pb, port;
  logic [1:0] mode;
  logic rsp, etbl, ehop, ind_o, alt_o;

  hier_route_sel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .my_grp_i(my_grp), .my_sw_i(my_sw),
    .wr_en_i(wr_en), .wr_inter_i(wr_inter), .wr_idx_i(wr_idx),
    .wr_va_i(wr_va), .wr_pa_i(wr_pa), .wr_vb_i(wr_vb), .wr_pb_i(wr_pb),
    .req_valid_i(req), .hdr_mode_i(mode), .hdr_ind_i(ind_i), .hdr_alt_i(alt_i),
    .hdr_mid_grp_i(mid_i), .hdr_dst_grp_i(dgrp), .hdr_dst_sw_i(dsw),
    .hdr_dst_host_i(dhost), .hdr_hops_i(hops_i),
    .rsp_valid_o(rsp), .port_o(port), .err_tbl_o(etbl), .err_hop_o(ehop),
    .hdr_ind_o(ind_o), .hdr_alt_o(alt_o), .hdr_mid_grp_o(mid_o), .hdr_hops_o(hops_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int rr_k = 0;
  logic [15:0] lfsr_m = 16'hACE1;

  task automatic chk(string req_tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  function automatic int cand(int k, int a, int b);
    int lo = (a < b) ? a : b;
    int hi = (a < b) ? b : a;
    int g = k;
    if (g >= lo) g++;
    if (g >= hi) g++;
    return g;
  endfunction

  task automatic wr(bit inter, int idx, bit va, int pa, bit vb, int pb);
    @(negedge clk);
    wr_en = 1; wr_inter = inter; wr_idx = 3'(idx);
    wr_va = va; wr_pa = 6'(pa); wr_vb = vb; wr_pb = 6'(pb);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic send(int md, bit ind, bit alt, int mid, int dg, int ds, int dh, int hp);
    @(negedge clk);
    req = 1; mode = 2'(md); ind_i = ind; alt_i = alt; mid_i = 3'(mid);
    dgrp = 3'(dg); dsw = 3'(ds); dhost = 3'(dh); hops_i = 3'(hp);
    @(negedge clk);
    req = 0;
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid after reset", int'(rsp), 0);
    send(0, 0, 0, 0, 4, 0, 0, 0);
    chk("R1 empty table error", int'(etbl), 1);
    chk("R11 empty table port", int'(port), 55);
  endtask

  task automatic t_load;
    for (int s = 0; s < 7; s++) wr(0, s, 1, 8 + s, 0, 0);
    for (int g = 0; g < G; g++) wr(1, g, 1, 39 + g, g != 1, 15 + g);
    send(0, 0, 0, 0, 4, 0, 0, 0);
    chk("R13 inter written port", int'(port), 43);
    chk("R13 inter written no error", int'(etbl), 0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R2 no request no response", int'(rsp), 0);
    send(0, 0, 0, 0, 2, 6, 0, 1);
    chk("R2 response after request", int'(rsp), 1);
    @(negedge clk);
    chk("R2 single response", int'(rsp), 0);
  endtask

  task automatic t_deliver;
    send(0, 0, 0, 0, 2, 3, 5, 2);
    chk("R3 host port", int'(port), 5);
    chk("R3 hops unchanged", int'(hops_o), 2);
    send(0, 0, 0, 0, 2, 3, 1, 3);
    chk("R12 delivery at limit no hop error", int'(ehop), 0);
    chk("R3 host port at limit", int'(port), 1);
  endtask

  task automatic t_intra;
    send(0, 0, 0, 0, 2, 6, 0, 1);
    chk("R4 intra port", int'(port), 14);
    chk("R4 hops+1", int'(hops_o), 2);
    send(0, 0, 0, 0, 2, 7, 0, 1);
    chk("R11 invalid intra error", int'(etbl), 1);
    chk("R11 invalid intra service port", int'(port), 55);
  endtask

  task automatic t_inter;
    send(0, 0, 0, 0, 5, 1, 0, 0);
    chk("R5 inter port", int'(port), 44);
    chk("R5 hops+1", int'(hops_o), 1);
    chk("R5 direct flag clear", int'(ind_o), 0);
  endtask

  task automatic t_multi;
    send(1, 0, 0, 0, 5, 0, 0, 0);
    chk("R6 first alt flag", int'(alt_o), 0);
    chk("R6 first port way a", int'(port), 44);
    send(1, 0, 0, 0, 5, 0, 0, 0);
    chk("R6 second alt flag", int'(alt_o), 1);
    chk("R6 second port way b", int'(port), 20);
    send(1, 0, 0, 0, 1, 0, 0, 0);
    chk("R6 third port way a", int'(port), 40);
    send(1, 0, 0, 0, 1, 0, 0, 0);
    chk("R6 fallback to way a", int'(port), 40);
    chk("R6 fallback alt flag", int'(alt_o), 1);
    send(1, 0, 1, 0, 4, 0, 0, 1);
    chk("R6 transit uses header flag", int'(port), 19);
    send(1, 0, 0, 0, 4, 0, 0, 0);
    chk("R6 transit did not toggle", int'(port), 43);
  endtask

  task automatic t_rr;
    for (int i = 0; i < 7; i++) begin
      int m = cand(rr_k, 2, 5);
      send(2, 0, 0, 0, 5, 0, 0, 0);
      chk("R7 rr intermediate", int'(mid_o), m);
      chk("R7 rr indirect flag", int'(ind_o), 1);
      chk("R7 rr port toward mid", int'(port), 39 + m);
      rr_k = (rr_k + 1) % (G - 2);
    end
    send(2, 0, 0, 0, 2, 6, 0, 0);
    chk("R9 own group stays direct", int'(ind_o), 0);
    chk("R9 own group port", int'(port), 14);
    send(2, 0, 0, 0, 5, 0, 0, 0);
    chk("R9 rr not advanced", int'(mid_o), cand(rr_k, 2, 5));
    rr_k = (rr_k + 1) % (G - 2);
  endtask

  task automatic t_rand;
    for (int i = 0; i < 5; i++) begin
      int m = cand(int'(lfsr_m % 16'd6), 0, 2);
      send(3, 0, 0, 0, 0, 0, 0, 0);
      chk("R8 random intermediate", int'(mid_o), m);
      chk("R8 random port", int'(port), 39 + m);
      lfsr_m = {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
    end
    send(3, 0, 0, 0, 2, 6, 0, 0);
    chk("R9 random own group direct", int'(ind_o), 0);
    send(3, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 lfsr not advanced", int'(mid_o), cand(int'(lfsr_m % 16'd6), 0, 2));
  endtask

  task automatic t_mid;
    send(2, 1, 0, 4, 6, 0, 0, 2);
    chk("R10 before mid port", int'(port), 43);
    chk("R10 before mid flag kept", int'(ind_o), 1);
    send(2, 1, 0, 2, 6, 0, 0, 2);
    chk("R10 at mid flag cleared", int'(ind_o), 0);
    chk("R10 at mid port toward dest", int'(port), 45);
  endtask

  task automatic t_hops;
    send(0, 0, 0, 0, 5, 0, 0, 2);
    chk("R12 direct below limit", int'(ehop), 0);
    send(0, 0, 0, 0, 5, 0, 0, 3);
    chk("R12 direct at limit error", int'(ehop), 1);
    chk("R12 direct error port", int'(port), 55);
    send(2, 0, 0, 0, 5, 0, 0, 4);
    chk("R12 indirect below limit", int'(ehop), 0);
    chk("R12 indirect below limit port", int'(port), 44);
    send(3, 0, 0, 0, 5, 0, 0, 5);
    chk("R12 indirect at limit error", int'(ehop), 1);
  endtask

  initial begin
    my_grp = MY_G; my_sw = MY_S;
    wr_en = 0; wr_inter = 0; wr_idx = 0; wr_va = 0; wr_pa = 0; wr_vb = 0; wr_pb = 0;
    req = 0; mode = 0; ind_i = 0; alt_i = 0; mid_i = 0; dgrp = 0; dsw = 0; dhost = 0; hops_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_load;
    t_idle;
    t_deliver;
    t_intra;
    t_inter;
    t_multi;
    t_rr;
    t_rand;
    t_mid;
    t_hops;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule